// File: doc/BRIEF.md
# Hierarchical Carry Look-Ahead Adder

This block adds two unsigned operands and a carry-in with no clock and no state. It produces the sum and the carry-out combinationally. No carry ripples from bit to bit. Each bit position has a reduced adder cell that emits three signals: a generate flag, a propagate flag and a sum bit. The cell has no carry logic of its own. Groups of four such cells feed a look-ahead unit. That unit forms the carry into every bit as a flat sum of products of the lower generates, the lower propagates and the group carry-in. It also reports whether the group as a whole generates or passes a carry.

A second look-ahead unit of the same shape takes the four group flags and computes the carry into each group. The result is a 16-bit adder. When `WIDTH` is 64, four 16-bit adders report block-level generate and propagate flags to a third look-ahead unit. The adder is meant to sit inside a datapath stage where the carry path sets the timing.

Top module: `cla_adder`

## Requirements
- R1: For every operand pair and carry-in, `{cout, sum}` equals the arithmetic value `op_a + op_b + cin`. This holds for both supported widths, 16 and 64.
- R2: With both operands zero, `sum` equals `cin` placed in bit 0 and `cout` is 0.
- R3: With both operands all ones and `cin` = 1, the result is the full-width generate case: `sum` is all ones and `cout` is 1.
- R4: When every bit position propagates (`op_a ^ op_b` all ones, with no position generating), the carry-in passes the whole width. `cout` equals `cin`, and `sum` is all ones when `cin` is 0 and all zeros when `cin` is 1.
- R5: When the most significant bit of both operands is 1, `cout` is 1 whatever the lower bits and `cin`.
- R6: When the most significant bit of both operands is 0, `cout` is 0 whatever the lower bits and `cin`.
- R7: A carry created in one 4-bit group reaches the next group and all higher groups. Example: 0x0FFF + 0x0001 = 0x1000 with `cout` 0, and 0x00FF + 0x0001 with `cin` 1 gives 0x0101.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum, modulo 2^WIDTH |
| cout | output | 1 | Carry out of the top bit |

## Verification
Random operand pairs with random carry-in check the arithmetic identity over a broad spread of generate and propagate mixes. Directed patterns then isolate single mechanisms. Zero operands show that the carry-in alone reaches the sum. Complementary operands form a full propagate chain, which shows that the carry-in crosses every group and block flag without being lost or generated. All-ones operands exercise the full generate case. Values such as 0x0FFF + 1 show that a carry enters the next group through the top-level unit rather than inside one group. Setting or clearing the top bits of both operands shows that the carry-out follows the top position regardless of lower bits.

// File: rtl/cla_pkg.sv
package cla_pkg;
    // bits per look-ahead group and groups per look-ahead level
    localparam int GRP_BITS  = 4;
    localparam int BLK_BITS  = GRP_BITS * GRP_BITS;
    localparam int WIDE_BITS = BLK_BITS * GRP_BITS;

    typedef struct packed {
        logic gen;
        logic prop;
    } gp_t;
endpackage

// File: rtl/cla_pfa.sv
// Per-bit cells without carry logic: generate, propagate, sum.
module cla_pfa #(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic [N-1:0] c_in,
    output logic [N-1:0] gen,
    output logic [N-1:0] prop,
    output logic [N-1:0] s
);
    for (genvar i = 0; i < N; i++) begin : g_cell
        assign gen[i]  = a[i] & b[i];
        assign prop[i] = a[i] ^ b[i];
        assign s[i]    = prop[i] ^ c_in[i];
    end
endmodule

// File: rtl/cla_lookahead.sv
// Flat two-level carry unit: carry into each position plus group flags.
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int N = GRP_BITS
) (
    input  logic [N-1:0] gen,
    input  logic [N-1:0] prop,
    input  logic         c0,
    output logic [N-1:0] carry,
    output gp_t          grp
);
    // sum of products for the carry into position tgt
    function automatic logic sop_carry(input logic [N-1:0] gv,
                                       input logic [N-1:0] pv,
                                       input logic         cv,
                                       input int           tgt);
        logic in_term;
        logic prod;
        logic acc;
        in_term = cv;
        for (int j = 0; j < N; j++)
            if (j < tgt) in_term = in_term & pv[j];
        acc = in_term;
        for (int s = 0; s < N; s++) begin
            if (s < tgt) begin
                prod = gv[s];
                for (int m = 0; m < N; m++)
                    if (m > s && m < tgt) prod = prod & pv[m];
                acc = acc | prod;
            end
        end
        return acc;
    endfunction

    for (genvar k = 0; k < N; k++) begin : g_carry
        assign carry[k] = sop_carry(gen, prop, c0, k);
    end

    gp_t grp_d;
    always_comb begin
        grp_d.gen  = sop_carry(gen, prop, 1'b0, N);
        grp_d.prop = &prop;
    end
    assign grp = grp_d;
endmodule

// File: rtl/cla_group4.sv
// One 4-bit look-ahead adder reporting group flags.
module cla_group4
    import cla_pkg::*;
(
    input  logic [GRP_BITS-1:0] a,
    input  logic [GRP_BITS-1:0] b,
    input  logic                c0,
    output logic [GRP_BITS-1:0] s,
    output gp_t                 grp
);
    logic [GRP_BITS-1:0] gen, prop, carry;

    cla_pfa #(.N(GRP_BITS)) u_pfa (
        .a(a), .b(b), .c_in(carry), .gen(gen), .prop(prop), .s(s)
    );

    cla_lookahead #(.N(GRP_BITS)) u_la (
        .gen(gen), .prop(prop), .c0(c0), .carry(carry), .grp(grp)
    );
endmodule

// File: rtl/cla_block16.sv
// Four groups joined by a second look-ahead unit.
module cla_block16
    import cla_pkg::*;
(
    input  logic [BLK_BITS-1:0] a,
    input  logic [BLK_BITS-1:0] b,
    input  logic                c0,
    output logic [BLK_BITS-1:0] s,
    output gp_t                 blk
);
    logic [GRP_BITS-1:0] g_gen, g_prop, g_cin;

    for (genvar i = 0; i < GRP_BITS; i++) begin : g_grp
        gp_t gf;
        cla_group4 u_grp (
            .a  (a[i*GRP_BITS +: GRP_BITS]),
            .b  (b[i*GRP_BITS +: GRP_BITS]),
            .c0 (g_cin[i]),
            .s  (s[i*GRP_BITS +: GRP_BITS]),
            .grp(gf)
        );
        assign g_gen[i]  = gf.gen;
        assign g_prop[i] = gf.prop;
    end

    cla_lookahead #(.N(GRP_BITS)) u_top (
        .gen(g_gen), .prop(g_prop), .c0(c0), .carry(g_cin), .grp(blk)
    );
endmodule

// File: rtl/cla_adder.sv
// Top: 16-bit adder, or 64-bit with a third look-ahead level.
module cla_adder
    import cla_pkg::*;
#(
    parameter int WIDTH = BLK_BITS
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam bit WIDE   = (WIDTH > BLK_BITS);
    localparam int N_BLKS = WIDE ? GRP_BITS : 1;

    gp_t top_d;

    if (!WIDE) begin : g_w16
        gp_t bf;
        cla_block16 u_blk (
            .a(op_a[BLK_BITS-1:0]), .b(op_b[BLK_BITS-1:0]),
            .c0(cin), .s(sum[BLK_BITS-1:0]), .blk(bf)
        );
        assign top_d = bf;
    end else begin : g_w64
        logic [N_BLKS-1:0] b_gen, b_prop, b_cin;
        for (genvar i = 0; i < N_BLKS; i++) begin : g_blk
            gp_t bf;
            cla_block16 u_blk (
                .a  (op_a[i*BLK_BITS +: BLK_BITS]),
                .b  (op_b[i*BLK_BITS +: BLK_BITS]),
                .c0 (b_cin[i]),
                .s  (sum[i*BLK_BITS +: BLK_BITS]),
                .blk(bf)
            );
            assign b_gen[i]  = bf.gen;
            assign b_prop[i] = bf.prop;
        end
        cla_lookahead #(.N(N_BLKS)) u_top (
            .gen(b_gen), .prop(b_prop), .c0(cin), .carry(b_cin), .grp(top_d)
        );
    end

    // carry out: top-level generate, or the carry-in passed through all
    assign cout = top_d.gen | (top_d.prop & cin);
endmodule

// File: rtl/cla_adder_chk.sv
module cla_adder_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout
);
    logic known;
    assign known = !$isunknown({op_a, op_b, cin, sum, cout});

    always_comb begin
        if (known) begin
            // R1
            sum_match_chk: assert ({cout, sum} ==
                ({1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, cin}));
            // R2
            zero_ops_chk: assert (!(op_a == '0 && op_b == '0) ||
                (cout == 1'b0 && sum == {{(WIDTH-1){1'b0}}, cin}));
            // R4
            full_prop_chk: assert (!((op_a ^ op_b) == '1 && (op_a & op_b) == '0) ||
                (cout == cin && sum == {WIDTH{~cin}}));
            // R5
            top_gen_chk: assert (!(op_a[WIDTH-1] & op_b[WIDTH-1]) || cout);
            // R6
            top_kill_chk: assert ((op_a[WIDTH-1] | op_b[WIDTH-1]) || !cout);
        end
    end
endmodule

bind cla_adder cla_adder_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/cla_adder_bench.sv
module cla_adder_bench;
    localparam int W16 = 16;
    localparam int W64 = 64;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;   // 200 MHz

    logic [W16-1:0] a16, b16, s16;
    logic           c16, co16;
    logic [W64-1:0] a64, b64, s64;
    logic           c64, co64;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    cla_adder #(.WIDTH(W16)) u_cla_adder (
        .op_a(a16), .op_b(b16), .cin(c16), .sum(s16), .cout(co16)
    );
    cla_adder #(.WIDTH(W64)) u_cla_adder_w64 (
        .op_a(a64), .op_b(b64), .cin(c64), .sum(s64), .cout(co64)
    );

    function automatic logic [W16:0] ref16(input logic [W16-1:0] x, y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W16{1'b0}}, c};
    endfunction
    function automatic logic [W64:0] ref64(input logic [W64-1:0] x, y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W64{1'b0}}, c};
    endfunction

    task automatic t16(input logic [W16-1:0] x, y, input logic c, input string req);
        logic [W16:0] exp;
        @(negedge clk);
        a16 = x; b16 = y; c16 = c;
        #1;
        exp = ref16(x, y, c);
        n_chk++;
        if ({co16, s16} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h",
                     req, x, y, c, {co16, s16}, exp);
        end
    endtask

    task automatic t64(input logic [W64-1:0] x, y, input logic c, input string req);
        logic [W64:0] exp;
        @(negedge clk);
        a64 = x; b64 = y; c64 = c;
        #1;
        exp = ref64(x, y, c);
        n_chk++;
        if ({co64, s64} !== exp) begin
            n_fail++;
            $display("FAIL %s: a=%h b=%h cin=%b got %h expected %h",
                     req, x, y, c, {co64, s64}, exp);
        end
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        for (int cyc = 0; cyc < 100000; cyc++) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        void'($urandom(32'd352));
        a16 = '0; b16 = '0; c16 = 1'b0;
        a64 = '0; b64 = '0; c64 = 1'b0;
        repeat (3) @(posedge clk);

        // R2 quiet state and zero operands
        t16('0, '0, 1'b0, "R2");
        t16('0, '0, 1'b1, "R2");
        t64('0, '0, 1'b1, "R2");
        // R3 all ones with carry-in
        t16('1, '1, 1'b1, "R3");
        t64('1, '1, 1'b1, "R3");
        // R4 full propagate chain
        t16('1, '0, 1'b1, "R4");
        t16('1, '0, 1'b0, "R4");
        t16(16'hA5C3, 16'h5A3C, 1'b1, "R4");
        t64('1, '0, 1'b1, "R4");
        t64(64'hF0F0_1234_5555_AAAA, 64'h0F0F_EDCB_AAAA_5555, 1'b1, "R4");
        // R5 top-bit generate
        t16(16'h8000, 16'h8000, 1'b0, "R5");
        t64({1'b1, 63'd0}, {1'b1, 63'd5}, 1'b0, "R5");
        // R6 top-bit kill
        t16(16'h7FFF, 16'h7FFF, 1'b1, "R6");
        t64({1'b0, {63{1'b1}}}, {1'b0, {63{1'b1}}}, 1'b1, "R6");
        // R7 carries across group and block boundaries
        t16(16'h0FFF, 16'h0001, 1'b0, "R7");
        t16(16'h00FF, 16'h0001, 1'b1, "R7");
        t16(16'h000F, 16'h0000, 1'b1, "R7");
        t64(64'h0000_0000_FFFF_FFFF, 64'h1, 1'b0, "R7");
        t64(64'h0000_FFFF_0000_0000, 64'h0000_0000_FFFF_FFFF, 1'b1, "R7");
        // R1 random sweep on both widths
        for (int i = 0; i < 3000; i++) begin
            t16(16'($urandom), 16'($urandom), 1'($urandom), "R1");
            t64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom), "R1");
        end
        done = 1'b1;
        report();
    end
endmodule